// File: doc/BRIEF.md
# Periodic Tick Timer with Maskable Interrupt

This block is a single down-counting timer that produces a periodic tick interrupt. Software programs a reload value into the divisor register. A control write with the load operation copies that value into the live counter and leaves the timer halted. A second control write with the run operation starts the countdown.

While the timer runs, a prescaler picks how often the counter steps, from every clock cycle down to one step in sixteen cycles. The step that would take the counter to zero is the wrap event. On that step the counter reloads from the divisor and a pending flag is set, so the interrupt period is exactly divisor steps. Software can read the live count at any time. The elapsed part of the current period is the divisor minus that count.

The interrupt has an enable mask and a masked-status readback. A separate write-one-to-clear acknowledge register clears the pending flag. All registers sit behind a simple word-addressed write strobe with a combinational read port.

Top module: `periodic_tick_timer`

## Requirements
- R1: After reset the timer is halted, and the count, divisor, mask and pending flag are all zero. Every register reads zero and `tick_irq` is low.
- R2: The divisor register at address 0 is read/write over its full 32-bit width.
- R3: The control register is at address 1. Write bits [1:0] select the operation: 0 none, 1 load, 2 run, 3 stop. Bits [3:2] select the step rate. Load copies the divisor into the counter and leaves the timer halted. Reading the register returns the running state in bit 0 and the step rate in bits [3:2].
- R4: While the timer is halted by stop or load, or runs with step-rate code 0, the count read at address 2 does not change.
- R5: With step-rate code c ≥ 1, the counter decrements once every 4^(c-1) clock cycles. The first step comes that many cycles after the run write.
- R6: A step taken at a count of 1 or 0 with a nonzero divisor reloads the divisor and sets the pending flag. The period is therefore divisor steps, and the read count jumps up at the wrap.
- R7: With a divisor of zero the counter settles at zero and the pending flag is never set.
- R8: The mask is bit 0 at address 3. Masked status at address 4, bit 0, equals pending AND mask, and `tick_irq` follows the same value.
- R9: Writing address 5 with bit 0 set clears the pending flag. Writing it with bit 0 clear has no effect.
- R10: When a wrap and an acknowledge fall in the same cycle, the pending flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address for write and read |
| reg_wr_data | input | 32 | Write data |
| reg_rd_data | output | 32 | Read data for reg_addr (combinational) |
| tick_irq | output | 1 | Masked interrupt request, held until acknowledged |

## Verification
The wrap step (reload plus flag set) and a software acknowledge write can land in the same clock cycle. The bench provokes this by starting the timer with a divisor of 4 at full step rate and timing the acknowledge write onto the fourth edge after the run write. It first confirms the count reads 1 one cycle earlier. The result is judged through the masked status, which must still read 1, and a second acknowledge one cycle later must clear it.

// File: rtl/ptt_pkg.sv
package ptt_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_LOAD = 2'd1,
    OP_RUN  = 2'd2,
    OP_STOP = 2'd3
  } ptt_op_e;

  localparam int unsigned A_DIVISOR = 0;
  localparam int unsigned A_CONTROL = 1;
  localparam int unsigned A_COUNT   = 2;
  localparam int unsigned A_MASK    = 3;
  localparam int unsigned A_STATUS  = 4;
  localparam int unsigned A_ACK     = 5;

  // clock cycles per counter step for a rate code; 0 means no stepping
  function automatic int unsigned tick_period(input int unsigned code,
                                              input int unsigned step_log2);
    if (code == 0) return 0;
    return 32'd1 << (step_log2 * (code - 1));
  endfunction

endpackage

// File: rtl/ptt_prescaler.sv
module ptt_prescaler #(
  parameter int FREQ_W   = 2,
  parameter int PRE_STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              enable,
  input  logic [FREQ_W-1:0] freq,
  output logic              tick
);
  localparam int NCODES     = 1 << FREQ_W;
  localparam int MAX_PERIOD = 1 << (PRE_STEP * (NCODES - 2));
  localparam int PRE_W      = $clog2(MAX_PERIOD + 1);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] period;

  always_comb begin
    period = PRE_W'(ptt_pkg::tick_period(32'(freq), PRE_STEP));
  end

  assign tick = enable && (period != '0) && (pre_q == period - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)                pre_q <= '0;
    else if (restart || !enable) pre_q <= '0;
    else if (tick)             pre_q <= '0;
    else                       pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/ptt_counter.sv
module ptt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             advance,
  input  logic [CNT_W-1:0] divisor,
  output logic [CNT_W-1:0] count,
  output logic             wrap_fire
);
  function automatic logic [CNT_W-1:0] step_value(input logic [CNT_W-1:0] cur,
                                                  input logic [CNT_W-1:0] div);
    return (cur <= CNT_W'(1)) ? div : cur - 1'b1;
  endfunction

  logic at_end;
  assign at_end    = advance && (count <= CNT_W'(1));
  assign wrap_fire = at_end && (divisor != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (load)    count <= divisor;
    else if (advance) count <= step_value(count, divisor);
  end
endmodule

// File: rtl/ptt_irq.sv
module ptt_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic ack,
  input  logic mask,
  output logic pending,
  output logic masked
);
  always_ff @(posedge clk) begin
    if (!rst_n)       pending <= 1'b0;
    else if (set_evt) pending <= 1'b1;
    else if (ack)     pending <= 1'b0;
  end

  assign masked = pending & mask;
endmodule

// File: rtl/periodic_tick_timer.sv
module periodic_tick_timer #(
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 32,
  parameter int ADDR_W   = 3,
  parameter int FREQ_W   = 2,
  parameter int PRE_STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wr_data,
  output logic [DATA_W-1:0] reg_rd_data,
  output logic              tick_irq
);
  import ptt_pkg::*;

  localparam int FREQ_LSB = 2;

  logic [CNT_W-1:0]  div_q;
  logic [CNT_W-1:0]  count_q;
  logic [FREQ_W-1:0] freq_q;
  logic              running_q;
  logic              mask_q;

  logic wr_div, wr_ctrl, wr_mask, wr_ack;
  logic ack_pulse, cnt_load, advance, tick, wrap_fire;
  logic irq_flag, irq_masked;
  ptt_op_e op;
  logic [FREQ_W-1:0] freq_new;

  assign wr_div  = reg_wr_en && (32'(reg_addr) == A_DIVISOR);
  assign wr_ctrl = reg_wr_en && (32'(reg_addr) == A_CONTROL);
  assign wr_mask = reg_wr_en && (32'(reg_addr) == A_MASK);
  assign wr_ack  = reg_wr_en && (32'(reg_addr) == A_ACK);

  assign op        = ptt_op_e'(reg_wr_data[1:0]);
  assign freq_new  = reg_wr_data[FREQ_LSB +: FREQ_W];
  assign ack_pulse = wr_ack && reg_wr_data[0];
  assign cnt_load  = wr_ctrl && (op == OP_LOAD);
  assign advance   = tick && running_q && !wr_ctrl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q     <= '0;
      freq_q    <= '0;
      running_q <= 1'b0;
      mask_q    <= 1'b0;
    end else begin
      if (wr_div)  div_q  <= reg_wr_data[CNT_W-1:0];
      if (wr_mask) mask_q <= reg_wr_data[0];
      if (wr_ctrl) begin
        freq_q <= freq_new;
        case (op)
          OP_LOAD: running_q <= 1'b0;
          OP_RUN:  running_q <= 1'b1;
          OP_STOP: running_q <= 1'b0;
          default: running_q <= running_q;
        endcase
      end
    end
  end

  ptt_prescaler #(.FREQ_W(FREQ_W), .PRE_STEP(PRE_STEP)) pre_i (
    .clk(clk), .rst_n(rst_n), .restart(wr_ctrl), .enable(running_q),
    .freq(freq_q), .tick(tick)
  );

  ptt_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .advance(advance),
    .divisor(div_q), .count(count_q), .wrap_fire(wrap_fire)
  );

  ptt_irq irq_i (
    .clk(clk), .rst_n(rst_n), .set_evt(wrap_fire), .ack(ack_pulse),
    .mask(mask_q), .pending(irq_flag), .masked(irq_masked)
  );

  assign tick_irq = irq_masked;

  always_comb begin
    reg_rd_data = '0;
    case (32'(reg_addr))
      A_DIVISOR: reg_rd_data = DATA_W'(div_q);
      A_CONTROL: begin
        reg_rd_data[0] = running_q;
        reg_rd_data[FREQ_LSB +: FREQ_W] = freq_q;
      end
      A_COUNT:   reg_rd_data = DATA_W'(count_q);
      A_MASK:    reg_rd_data[0] = mask_q;
      A_STATUS:  reg_rd_data[0] = irq_masked;
      default:   reg_rd_data = '0;
    endcase
  end
endmodule

// File: rtl/ptt_checker.sv
module ptt_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] divisor,
  input logic             running,
  input logic             ctrl_wr,
  input logic             wrap_fire,
  input logic             ack,
  input logic             flag,
  input logic             mask,
  input logic             irq
);
  a_r4_halted_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !ctrl_wr) |=> (count == $past(count)));

  a_r6_wrap_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_fire |=> (count == $past(divisor)));

  a_r6_flag_from_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(wrap_fire));

  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !wrap_fire) |=> !flag);

  a_r10_collision_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && wrap_fire) |=> flag);

  a_r8_mask_gates: assert property (@(posedge clk) disable iff (!rst_n)
    !mask |-> !irq);
endmodule

bind periodic_tick_timer ptt_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .count(count_q), .divisor(div_q),
  .running(running_q), .ctrl_wr(wr_ctrl), .wrap_fire(wrap_fire),
  .ack(ack_pulse), .flag(irq_flag), .mask(mask_q), .irq(tick_irq)
);

// File: tb/periodic_tick_timer_tb_top.sv
module periodic_tick_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] reg_rd_data;
  logic        tick_irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  periodic_tick_timer dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data), .tick_irq(tick_irq)
  );

  localparam logic [2:0] DIV = 3'd0, CTL = 3'd1, CNT = 3'd2, MSK = 3'd3,
                         STA = 3'd4, ACK = 3'd5;

  function automatic logic [31:0] ctl_word(input int op, input int rate);
    return 32'((rate << 2) | op);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wr_data = d;
    @(posedge clk); #1;
    reg_wr_en = 1'b0; reg_wr_data = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rd_data;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 6; a++) begin rd(3'(a), v); check("R1 reset read", v, 0); end
    check("R1 irq low", 32'(tick_irq), 0);
  endtask

  task automatic t_divider();
    logic [31:0] v;
    wr(DIV, 32'hDEADBEEF); rd(DIV, v); check("R2 divisor rw", v, 32'hDEADBEEF);
  endtask

  task automatic t_load_run_wrap();
    logic [31:0] v, c1;
    wr(MSK, 1); wr(DIV, 10);
    wr(CTL, ctl_word(1, 1)); rd(CNT, v); check("R3 load copies", v, 10);
    wait_cyc(5); rd(CNT, v); check("R3 load halts", v, 10);
    wr(CTL, ctl_word(2, 1)); rd(CTL, v); check("R3 ctrl readback", v, 32'h5);
    wait_cyc(3); rd(CNT, v); check("R5 step per cycle", v, 7);
    wait_cyc(6); rd(CNT, v); check("R6 before wrap", v, 1);
    check("R6 no irq before wrap", 32'(tick_irq), 0);
    wait_cyc(1); rd(CNT, v); check("R6 reload larger", v, 10);
    check("R6 irq on wrap", 32'(tick_irq), 1);
    wr(CTL, ctl_word(3, 1)); rd(CNT, c1);
    wait_cyc(5); rd(CNT, v); check("R4 stop freezes", v, c1);
    wr(MSK, 0); rd(STA, v); check("R8 masked status off", v, 0);
    check("R8 irq masked", 32'(tick_irq), 0);
    wr(MSK, 1); rd(STA, v); check("R8 masked status on", v, 1);
    wr(ACK, 0); rd(STA, v); check("R9 ack zero ignored", v, 1);
    wr(ACK, 1); rd(STA, v); check("R9 ack clears", v, 0);
    check("R9 irq dropped", 32'(tick_irq), 0);
  endtask

  task automatic t_rates();
    logic [31:0] v, c1;
    wr(DIV, 3); wr(CTL, ctl_word(1, 2)); wr(CTL, ctl_word(2, 2));
    wait_cyc(3); rd(CNT, v); check("R5 rate2 no step yet", v, 3);
    wait_cyc(1); rd(CNT, v); check("R5 rate2 first step", v, 2);
    wait_cyc(4); rd(CNT, v); check("R5 rate2 second step", v, 1);
    wait_cyc(4); rd(CNT, v); check("R6 rate2 wrap", v, 3);
    rd(STA, v); check("R6 rate2 flag", v, 1);
    wr(CTL, ctl_word(2, 0)); rd(CNT, c1);
    wait_cyc(10); rd(CNT, v); check("R4 rate0 holds", v, c1);
    wr(ACK, 1);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    wr(CTL, ctl_word(3, 1)); wr(ACK, 1); wr(DIV, 4);
    wr(CTL, ctl_word(1, 1)); wr(CTL, ctl_word(2, 1));
    wait_cyc(3); rd(CNT, v); check("R10 count before wrap", v, 1);
    wr(ACK, 1); rd(STA, v); check("R10 wrap beats ack", v, 1);
    rd(CNT, v); check("R10 reload", v, 4);
    wr(ACK, 1); rd(STA, v); check("R9 later ack clears", v, 0);
    wr(CTL, ctl_word(3, 1));
  endtask

  task automatic t_div_zero();
    logic [31:0] v;
    wr(ACK, 1); wr(DIV, 0); wr(CTL, ctl_word(1, 1));
    wr(CTL, ctl_word(2, 1)); wait_cyc(20);
    rd(CNT, v); check("R7 zero divisor count", v, 0);
    rd(STA, v); check("R7 zero divisor no flag", v, 0);
  endtask

  initial begin
    wait_cyc(3); @(posedge clk); #1; rst_n = 1'b1;
    t_reset(); t_divider(); t_load_run_wrap(); t_rates();
    t_collision(); t_div_zero();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk);
        errors++; checks++; $display("FAIL watchdog expired"); end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule